// File: doc/BRIEF.md
# Shift Register and FIFO Interface for a Programmable IO State Machine

This block holds the input shift register (ISR) and the output shift register (OSR) of one programmable IO state machine. Each register has a saturating shift counter. The block also holds a small receive FIFO, which takes data from the machine towards the CPU, and a small transmit FIFO, which takes data from the CPU towards the machine. The control core issues one operation per cycle: shift-in, shift-out, push or pull. The block carries out that operation. While a blocking push or pull cannot complete, it holds the stall output high. It also reports whether the OSR still holds unshifted data, so that the core can use this as a jump condition.

Shift direction is chosen separately for each register. Two thresholds are programmable: one that a push compares against and one that a pull compares against. A push or a pull can be made conditional on its threshold. Each can also either stall or skip when its FIFO cannot serve it. The CPU side of both FIFOs is a plain valid/ready pair.

Top module: `sm_shift_unit`

## Requirements
- R1: After reset, the ISR and the input shift count are zero and the output shift count is 32, so osr_not_empty is low. Both FIFOs are empty: rx_valid is low and tx_ready is high. stall is low.
- R2: A shift-in (op_kind 0) takes n bits from the source selected by op_sel: 0 pins_in, 1 x_in, 2 y_in, 3 zeros, 6 the ISR itself, 7 the OSR. Shifting left, the ISR becomes (ISR << n) with the low n source bits in its low end. Shifting right (isr_right=1), it becomes (ISR >> n) with the low n source bits placed at its top.
- R3: An op_count, push_thr or pull_thr field of 0 stands for 32. A 32-bit shift-in or shift-out moves the whole word.
- R4: A shift-out (op_kind 1) raises out_valid in the same cycle, with out_dest equal to op_sel. Shifting left, out_data is the top n OSR bits, right-aligned, and the OSR is then shifted left by n. Shifting right (osr_right=1), out_data is the low n bits and the OSR is then shifted right by n.
- R5: A shift-out with op_sel 6 also loads the ISR with the shifted-out data and sets the input shift count to n.
- R6: Each shift adds n to its counter, and the counter saturates at 32.
- R7: A push (op_kind 2) that completes writes the ISR into the receive FIFO and clears both the ISR and the input count. Data leaves rx_data in the order it was pushed.
- R8: A push with op_block=1 while the receive FIFO is full raises stall and changes nothing. With op_block=0 it does not stall, writes nothing, and leaves the ISR intact.
- R9: A push with op_cond=1 does nothing, and does not stall, while the input count is below push_thr.
- R10: A pull (op_kind 3) from a non-empty transmit FIFO loads the OSR with the oldest entry and clears the output count.
- R11: A pull from an empty transmit FIFO stalls when op_block=1. When op_block=0 it loads x_in into the OSR and clears the output count.
- R12: A pull with op_cond=1 does nothing while the output count is below pull_thr.
- R13: osr_not_empty is high exactly while the output count is below pull_thr.
- R14: Each FIFO holds 4 entries. rx_valid is high while the receive FIFO holds data. tx_ready is low once the transmit FIFO holds 4 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_kind | input | 2 | 0 shift-in, 1 shift-out, 2 push, 3 pull |
| op_sel | input | 3 | Source of a shift-in or destination of a shift-out |
| op_count | input | 5 | Bit count, 0 means 32 |
| op_cond | input | 1 | Act only when the threshold is reached (push/pull) |
| op_block | input | 1 | Stall instead of skipping (push/pull) |
| isr_right | input | 1 | ISR shifts right when high |
| osr_right | input | 1 | OSR shifts right when high |
| push_thr | input | 5 | Push threshold, 0 means 32 |
| pull_thr | input | 5 | Pull threshold, 0 means 32 |
| pins_in | input | 32 | Pin values for shift-in |
| x_in | input | 32 | Scratch register X value |
| y_in | input | 32 | Scratch register Y value |
| stall | output | 1 | Issued blocking push or pull cannot complete |
| osr_not_empty | output | 1 | Output count below pull threshold |
| out_valid | output | 1 | Shift-out data present |
| out_dest | output | 3 | Destination code of the shift-out |
| out_data | output | 32 | Shifted-out bits, right-aligned |
| tx_valid | input | 1 | CPU offers a transmit word |
| tx_ready | output | 1 | Transmit FIFO can accept a word |
| tx_data | input | 32 | Transmit word |
| rx_valid | output | 1 | Receive FIFO has a word |
| rx_ready | input | 1 | CPU takes the receive word |
| rx_data | output | 32 | Oldest receive word |

## Verification
Shift-ins are swept over every bit count in both directions, with distinct pin and X patterns. A wrong mask or a wrong shift amount therefore shows up at a specific count, and a reversed direction shows up everywhere. Shift-outs are swept the same way and followed by a second, shorter shift. This separates a bad data slice from a bad remainder in the OSR. The conditional push is tried one bit below and exactly at every threshold from 1 to 32, which exposes off-by-one compares and counter wrap. Fill-to-full sequences with blocking and non-blocking pushes and pulls distinguish a stall from a skip, and a skip from a silent overwrite.

// File: rtl/sm_shift_unit.sv
module sm_shift_unit #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   op_valid,
  input  logic [1:0]             op_kind,
  input  logic [2:0]             op_sel,
  input  logic [$clog2(DW)-1:0]  op_count,
  input  logic                   op_cond,
  input  logic                   op_block,
  input  logic                   isr_right,
  input  logic                   osr_right,
  input  logic [$clog2(DW)-1:0]  push_thr,
  input  logic [$clog2(DW)-1:0]  pull_thr,
  input  logic [DW-1:0]          pins_in,
  input  logic [DW-1:0]          x_in,
  input  logic [DW-1:0]          y_in,
  output logic                   stall,
  output logic                   osr_not_empty,
  output logic                   out_valid,
  output logic [2:0]             out_dest,
  output logic [DW-1:0]          out_data,
  input  logic                   tx_valid,
  output logic                   tx_ready,
  input  logic [DW-1:0]          tx_data,
  output logic                   rx_valid,
  input  logic                   rx_ready,
  output logic [DW-1:0]          rx_data
);
  localparam int NW = $clog2(DW);
  localparam int CW = NW + 1;
  localparam int AW = $clog2(DEPTH);
  localparam logic [CW-1:0] FULLW = CW'(DW);

  typedef enum logic [1:0] {K_IN = 2'd0, K_OUT = 2'd1, K_PUSH = 2'd2, K_PULL = 2'd3} kind_t;

  function automatic logic [CW-1:0] widen(input logic [NW-1:0] f);
    return (f == '0) ? FULLW : {1'b0, f};
  endfunction

  function automatic logic [CW-1:0] sat_add(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic [CW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s > (CW+1)'(DW)) ? FULLW : s[CW-1:0];
  endfunction

  logic [DW-1:0] isr, osr;
  logic [CW-1:0] isc, osc;

  logic [DW-1:0] rx_mem [DEPTH];
  logic [DW-1:0] tx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp, tx_wp, tx_rp;
  logic [AW:0]   rx_cnt, tx_cnt;

  wire [CW-1:0] n       = widen(op_count);
  wire [CW-1:0] push_tv = widen(push_thr);
  wire [CW-1:0] pull_tv = widen(pull_thr);

  wire is_in   = op_valid && (kind_t'(op_kind) == K_IN);
  wire is_out  = op_valid && (kind_t'(op_kind) == K_OUT);
  wire is_push = op_valid && (kind_t'(op_kind) == K_PUSH);
  wire is_pull = op_valid && (kind_t'(op_kind) == K_PULL);

  wire rx_full  = (rx_cnt == (AW+1)'(DEPTH));
  wire tx_empty = (tx_cnt == '0);

  wire push_try = is_push && (!op_cond || (isc >= push_tv));
  wire pull_try = is_pull && (!op_cond || (osc >= pull_tv));
  wire push_do  = push_try && !rx_full;
  wire pull_do  = pull_try && !tx_empty;
  wire pull_x   = pull_try && tx_empty && !op_block;

  assign stall = op_block && ((push_try && rx_full) || (pull_try && tx_empty));

  logic [DW-1:0] in_src;
  always_comb begin
    case (op_sel)
      3'd0:    in_src = pins_in;
      3'd1:    in_src = x_in;
      3'd2:    in_src = y_in;
      3'd6:    in_src = isr;
      3'd7:    in_src = osr;
      default: in_src = '0;
    endcase
  end

  wire [DW-1:0] low_mask = ~({DW{1'b1}} << n);
  wire [DW-1:0] isr_next = isr_right ? ((isr >> n) | (in_src << (FULLW - n)))
                                     : ((isr << n) | (in_src & low_mask));
  wire [DW-1:0] out_bits = osr_right ? (osr & low_mask) : (osr >> (FULLW - n));
  wire [DW-1:0] osr_rest = osr_right ? (osr >> n) : (osr << n);

  assign out_valid     = is_out;
  assign out_dest      = op_sel;
  assign out_data      = out_bits;
  assign osr_not_empty = (osc < pull_tv);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr <= '0;
      isc <= '0;
    end else if (is_in) begin
      isr <= isr_next;
      isc <= sat_add(isc, n);
    end else if (is_out && op_sel == 3'd6) begin
      isr <= out_bits;
      isc <= n;
    end else if (push_do) begin
      isr <= '0;
      isc <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      osr <= '0;
      osc <= FULLW;
    end else if (is_out) begin
      osr <= osr_rest;
      osc <= sat_add(osc, n);
    end else if (pull_do) begin
      osr <= tx_mem[tx_rp];
      osc <= '0;
    end else if (pull_x) begin
      osr <= x_in;
      osc <= '0;
    end
  end

  wire rx_rd = rx_valid && rx_ready;
  wire tx_wr = tx_valid && tx_ready;

  assign rx_valid = (rx_cnt != '0);
  assign rx_data  = rx_mem[rx_rp];
  assign tx_ready = (tx_cnt != (AW+1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (push_do) rx_mem[rx_wp] <= isr;
    if (tx_wr)   tx_mem[tx_wp] <= tx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (push_do) rx_wp <= rx_wp + 1'b1;
      if (rx_rd)   rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + {{AW{1'b0}}, push_do} - {{AW{1'b0}}, rx_rd};
      if (tx_wr)   tx_wp <= tx_wp + 1'b1;
      if (pull_do) tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + {{AW{1'b0}}, tx_wr} - {{AW{1'b0}}, pull_do};
    end
  end

  AST_PUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) push_do |=> (isr == '0 && isc == '0)); // R7
  AST_PULL_ARMS: assert property (@(posedge clk) disable iff (!rst_n) (pull_do || pull_x) |=> (osc == '0 && osr_not_empty)); // R10
  AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n) stall |=> ($stable(isr) && $stable(osr) && $stable(isc) && $stable(osc))); // R8
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (isc <= FULLW && osc <= FULLW)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) rx_full |=> (rx_cnt <= (AW+1)'(DEPTH) && tx_cnt <= (AW+1)'(DEPTH))); // R14
endmodule

// File: tb/sm_shift_unit_tb.sv
module sm_shift_unit_tb_top;
  logic clk = 0, rst_n = 0;
  logic op_valid = 0, op_cond = 0, op_block = 0, isr_right = 0, osr_right = 0;
  logic [1:0] op_kind = 0;
  logic [2:0] op_sel = 0;
  logic [4:0] op_count = 0, push_thr = 0, pull_thr = 0;
  logic [31:0] pins_in = 0, x_in = 0, y_in = 0, tx_data = 0;
  logic tx_valid = 0, rx_ready = 0;
  logic stall, osr_not_empty, out_valid, tx_ready, rx_valid;
  logic [2:0] out_dest;
  logic [31:0] out_data, rx_data;

  sm_shift_unit dut_i (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  logic [31:0] mis = 0, mos = 0;
  int mic = 0, moc = 32, pth = 32, lth = 32;
  bit ir = 0, orr = 0;
  logic [31:0] rxq[$], txq[$];

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] shin(logic [31:0] cur, logic [31:0] s, int n, bit right);
    if (n == 32) return s;
    if (right) return (cur >> n) | (s << (32 - n));
    return (cur << n) | (s & ((32'h1 << n) - 1));
  endfunction

  function automatic logic [31:0] srcv(logic [2:0] s);
    case (s)
      3'd0: return pins_in;
      3'd1: return x_in;
      3'd2: return y_in;
      3'd6: return mis;
      3'd7: return mos;
      default: return 32'h0;
    endcase
  endfunction

  function automatic int smin(int a);
    return (a > 32) ? 32 : a;
  endfunction

  task automatic op(input logic [1:0] k, input logic [2:0] s, input int n,
                    input bit cnd, input bit blk, input string rq);
    bit es, tp, tl;
    logic [31:0] ed;
    es = 0; tp = 0; tl = 0; ed = 0;
    @(negedge clk);
    op_valid = 1; op_kind = k; op_sel = s; op_count = n[4:0]; op_cond = cnd; op_block = blk;
    #1;
    if (k == 2'd2) begin
      tp = !cnd || (mic >= pth);
      es = tp && (rxq.size() == 4) && blk;
    end
    if (k == 2'd3) begin
      tl = !cnd || (moc >= lth);
      es = tl && (txq.size() == 0) && blk;
    end
    chk(stall == es, rq, {31'b0, stall}, {31'b0, es});
    if (k == 2'd1) begin
      if (n == 32) ed = mos;
      else ed = orr ? (mos & ((32'h1 << n) - 1)) : (mos >> (32 - n));
      chk(out_valid && out_dest == s && out_data == ed, rq, out_data, ed);
    end
    @(posedge clk); #1;
    op_valid = 0;
    case (k)
      2'd0: begin mis = shin(mis, srcv(s), n, ir); mic = smin(mic + n); end
      2'd1: begin
        if (s == 3'd6) begin mis = ed; mic = n; end
        mos = (n == 32) ? 32'h0 : (orr ? (mos >> n) : (mos << n));
        moc = smin(moc + n);
      end
      2'd2: if (tp && rxq.size() < 4) begin rxq.push_back(mis); mis = 0; mic = 0; end
      default: if (tl) begin
        if (txq.size() > 0) begin mos = txq.pop_front(); moc = 0; end
        else if (!blk) begin mos = x_in; moc = 0; end
      end
    endcase
    chk(osr_not_empty == (moc < lth), "R13", {31'b0, osr_not_empty}, {31'b0, moc < lth});
  endtask

  task automatic rd_rx(input string rq);
    logic [31:0] e;
    @(negedge clk); #1;
    if (rxq.size() == 0) chk(rx_valid == 0, rq, {31'b0, rx_valid}, 32'h0);
    else begin
      e = rxq.pop_front();
      chk(rx_valid == 1, rq, {31'b0, rx_valid}, 32'h1);
      chk(rx_data == e, rq, rx_data, e);
      rx_ready = 1;
      @(posedge clk); #1;
      rx_ready = 0;
    end
  endtask

  task automatic tx_wr(input logic [31:0] d);
    @(negedge clk); #1;
    if (txq.size() < 4) txq.push_back(d);
    tx_valid = 1; tx_data = d;
    @(posedge clk); #1;
    tx_valid = 0;
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk(rx_valid == 0, "R1", {31'b0, rx_valid}, 0);
    chk(tx_ready == 1, "R1", {31'b0, tx_ready}, 1);
    chk(osr_not_empty == 0, "R1", {31'b0, osr_not_empty}, 0);
    chk(stall == 0, "R1", {31'b0, stall}, 0);
    op(2, 0, 32, 0, 1, "R1");
    rd_rx("R1");

    // R11 non-blocking pull from empty loads X, giving the OSR a known value
    x_in = 32'hC0FF_EE11;
    op(3, 0, 32, 0, 0, "R11");
    op(3, 0, 32, 0, 1, "R11");

    for (int dir = 0; dir < 2; dir++) begin
      isr_right = dir[0]; ir = dir[0];
      for (int n = 1; n <= 32; n++) begin
        pins_in = 32'hA5C3_0F96 ^ (n << 3);
        x_in    = 32'h1357_9BDF + n * 7;
        op(0, 0, 32, 0, 0, "R3");
        op(0, 1, n, 0, 0, (n == 32) ? "R3" : "R2");
        op(2, 0, 32, 0, 1, "R7");
        rd_rx((n == 32) ? "R3" : "R2");
      end
      y_in = 32'h5A5A_F00F;
      for (int s = 2; s < 8; s++) begin
        if (s == 4 || s == 5) continue;
        op(0, 0, 32, 0, 0, "R2");
        op(0, s[2:0], 5 + s, 0, 0, "R2");
        op(2, 0, 32, 0, 1, "R2");
        rd_rx("R2");
      end
    end
    isr_right = 0; ir = 0;

    for (int t = 1; t <= 32; t++) begin
      push_thr = t[4:0]; pth = t;
      if (t > 1) op(0, 2, t - 1, 0, 0, "R9");
      op(2, 0, 32, 1, 1, "R9");
      rd_rx("R9");
      op(0, 2, 1, 0, 0, "R9");
      op(2, 0, 32, 1, 1, "R9");
      rd_rx("R9");
    end
    push_thr = 0; pth = 32;
    op(0, 1, 32, 0, 0, "R6");
    op(0, 2, 32, 0, 0, "R6");
    op(2, 0, 32, 1, 1, "R6");
    rd_rx("R6");

    for (int i = 0; i < 4; i++) begin
      x_in = 32'h1000_0001 * (i + 3);
      op(0, 1, 32, 0, 0, "R7");
      op(2, 0, 32, 0, 1, "R7");
    end
    x_in = 32'hBEEF_0005;
    op(0, 1, 32, 0, 0, "R8");
    op(2, 0, 32, 0, 1, "R8");
    op(2, 0, 32, 0, 0, "R8");
    for (int i = 0; i < 4; i++) rd_rx("R7");
    op(2, 0, 32, 0, 1, "R8");
    rd_rx("R8");

    for (int i = 0; i < 4; i++) tx_wr(32'h7700_0000 + i);
    #1;
    chk(tx_ready == 0, "R14", {31'b0, tx_ready}, 0);
    tx_wr(32'hDEAD_0000);
    for (int i = 0; i < 4; i++) begin
      op(3, 0, 32, 0, 1, "R10");
      op(1, 1, 32, 0, 0, "R10");
    end

    for (int dir = 0; dir < 2; dir++) begin
      osr_right = dir[0]; orr = dir[0];
      for (int n = 1; n <= 32; n++) begin
        tx_wr(32'h8E1F_2C3D ^ (n * 32'h0101_0101));
        op(3, 0, 32, 0, 1, "R10");
        op(1, 3'(n % 6), n, 0, 0, (n == 32) ? "R3" : "R4");
        op(1, 3'((n + 1) % 6), (n % 7) + 1, 0, 0, "R4");
      end
    end
    osr_right = 0; orr = 0;

    tx_wr(32'hF00D_CAFE);
    op(3, 0, 32, 0, 1, "R5");
    op(1, 6, 12, 0, 0, "R5");
    push_thr = 12; pth = 12;
    op(2, 0, 32, 1, 1, "R5");
    rd_rx("R5");
    push_thr = 0; pth = 32;

    pull_thr = 8; lth = 8;
    op(1, 0, 32, 0, 0, "R13");
    op(3, 0, 32, 0, 1, "R11");
    x_in = 32'h2468_ACE1;
    op(3, 0, 32, 0, 0, "R11");
    op(1, 0, 5, 0, 0, "R13");
    tx_wr(32'h0BAD_F00D);
    op(3, 0, 32, 1, 1, "R12");
    op(1, 0, 3, 0, 0, "R12");
    op(3, 0, 32, 1, 1, "R12");
    op(1, 1, 32, 0, 0, "R12");
    op(3, 0, 32, 1, 1, "R12");
    pull_thr = 0; lth = 32;

    summary();
    $finish;
  end
endmodule